// File: doc/BRIEF.md
# Interrupt Message Destination Decoder

This block turns one interrupt request into a per-core delivery mask for a cluster of cores (eight by default). A request is either a message-signalled interrupt write, which is a 32-bit address and a 32-bit data word, or an inter-processor command, which is a low and a high command word. The block also returns the vector, the delivery mode, the trigger mode and the level bit. For every core there is a programmable physical ID, an 8-bit logical ID and a 4-bit destination model, all loaded through a small configuration write port.

The match logic works on all cores at once. It evaluates the physical match, the flat logical match and the cluster logical match in parallel. A shorthand taken from the command word can replace the decoded mask. For lowest-priority delivery, only the lowest-numbered core in the mask is kept. Bus transport, focus-processor arbitration and redirection hints are out of scope; redirection hints are ignored.

The control path is a two-state machine. ST_IDLE moves to ST_EMIT when `req_valid` is high (transition T_ACCEPT). ST_EMIT stays in ST_EMIT when another request arrives back to back (T_CHAIN) and otherwise returns to ST_IDLE (T_DONE). In ST_IDLE with no request the machine stays put (T_WAIT). `out_valid` is high exactly in ST_EMIT. A request is captured at the clock edge where `req_valid` is high, and its result appears on the outputs in the cycle after that edge.

Top module: `msg_irq_router`

## Requirements
- R1: A message request (`req_is_cmd`=0) takes its fields from the following bits. Destination ID is address bits 19:12 and logical mode is address bit 2 (1 = logical). Vector is data bits 7:0, delivery mode is data bits 10:8, level is data bit 14 and trigger is data bit 15. All other address and data bits are ignored, including address bit 3 (redirection hint) and data bits 19:18.
- R2: A command request (`req_is_cmd`=1) takes the destination ID from `req_addr` bits 31:24 and logical mode from `req_data` bit 11. It takes the shorthand from `req_data` bits 19:18. Vector, delivery mode, level and trigger sit in the same `req_data` positions as in R1.
- R3: In physical mode, destination 0xFF selects every core. Any other destination selects each core whose physical ID equals it.
- R4: In logical mode, a core with model 0xF (flat) matches when the destination AND its logical ID is nonzero.
- R5: In logical mode, a core with model 0x0 (cluster) matches when the upper nibbles of the destination and the logical ID are equal and the lower nibbles share a set bit. A core with any other model never matches in logical mode.
- R6: Shorthand 0 uses the decoded mask. Shorthand 1 selects only the core given by `req_sender`. Shorthand 2 selects all cores. Shorthand 3 selects all cores except `req_sender`. A message always behaves as shorthand 0.
- R7: With delivery mode 1 (lowest priority), only the lowest-numbered core of the mask remains. With any other mode, the mask is passed through unchanged.
- R8: `out_valid` is a one-cycle pulse in the cycle after each accepted request. The result outputs change only when a request is accepted.
- R9: `out_no_target` is 1 exactly when the delivered mask is all zero.
- R10: A configuration write loads the physical ID, logical ID and model of core `cfg_core`, and requests from the next cycle on use the new values. After reset, each core has physical ID equal to its index, logical ID 0 and model 0xF, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_core | input | 3 | Core index being configured |
| cfg_phys_id | input | 8 | Physical ID to load |
| cfg_log_id | input | 8 | Logical ID to load |
| cfg_model | input | 4 | Destination model to load (0xF flat, 0x0 cluster) |
| req_valid | input | 1 | Request strobe |
| req_is_cmd | input | 1 | 0 = message write, 1 = inter-processor command |
| req_sender | input | 3 | Index of the issuing core (command shorthand) |
| req_addr | input | 32 | Message address, or command high word |
| req_data | input | 32 | Message data, or command low word |
| out_valid | output | 1 | Result valid pulse |
| out_mask | output | 8 | Per-core delivery mask |
| out_vector | output | 8 | Vector |
| out_dmode | output | 3 | Delivery mode |
| out_trig | output | 1 | Trigger mode (1 = level) |
| out_level | output | 1 | Level bit |
| out_no_target | output | 1 | Mask is empty |

## Verification
The assertions check the following on every cycle:
- a valid pulse follows every request and no pulse appears without one;
- a lowest-priority result never has more than one bit set;
- shorthand 3 never selects the sender;
- physical destination 0xFF reaches every core;
- a configuration write lands in the addressed core's entry.

Only the bench's scenarios can show the match rules themselves. These include flat and cluster matching on mixed core populations, a model value outside the two supported ones, bits that must be ignored, empty masks, and the effect of reprogramming an ID.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
    localparam logic [2:0] DM_LOWPRI     = 3'd1;
    localparam logic [7:0] DEST_BCAST    = 8'hFF;

    typedef struct packed {
        logic [7:0] phys;
        logic [7:0] logid;
        logic [3:0] model;
    } core_cfg_t;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } route_state_e;

endpackage

// File: rtl/irq_core_cfg.sv
module irq_core_cfg
    import irq_route_pkg::*;
#(
    parameter int NCORES = 8,
    localparam int IDXW  = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDXW-1:0]             core,
    input  core_cfg_t                   wdata,
    output core_cfg_t [NCORES-1:0]      cfg_o
);

    for (genvar c = 0; c < NCORES; c++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[c].phys  <= 8'(c);
                cfg_o[c].logid <= '0;
                cfg_o[c].model <= MODEL_FLAT;
            end else if (we && (core == IDXW'(c))) begin
                cfg_o[c] <= wdata;
            end
        end
    end

    // R10: a write lands in the addressed entry
    a_r10_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rst_n) |=> (cfg_o[$past(core)] == $past(wdata)));

endmodule

// File: rtl/irq_core_match.sv
module irq_core_match
    import irq_route_pkg::*;
(
    input  core_cfg_t  cfg,
    input  logic [7:0] dest,
    input  logic       logical,
    output logic       hit
);

    logic phys_hit;
    logic flat_hit;
    logic clus_hit;

    always_comb begin
        phys_hit = (dest == DEST_BCAST) || (dest == cfg.phys);
        flat_hit = (cfg.model == MODEL_FLAT) && ((dest & cfg.logid) != 8'h00);
        clus_hit = (cfg.model == MODEL_CLUSTER)
                && (dest[7:4] == cfg.logid[7:4])
                && ((dest[3:0] & cfg.logid[3:0]) != 4'h0);
        hit      = logical ? (flat_hit || clus_hit) : phys_hit;
    end

endmodule

// File: rtl/irq_target_select.sv
module irq_target_select
    import irq_route_pkg::*;
#(
    parameter int NCORES = 8,
    localparam int IDXW  = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic [NCORES-1:0] decoded,
    input  shorthand_e        sh,
    input  logic [IDXW-1:0]   sender,
    input  logic [2:0]        dmode,
    output logic [NCORES-1:0] mask_o
);

    logic [NCORES-1:0] self_bit;
    logic [NCORES-1:0] picked;

    always_comb begin
        self_bit = '0;
        self_bit[sender] = 1'b1;
        unique case (sh)
            SH_NONE:   picked = decoded;
            SH_SELF:   picked = self_bit;
            SH_ALL:    picked = '1;
            SH_OTHERS: picked = ~self_bit;
            default:   picked = decoded;
        endcase
        if (dmode == DM_LOWPRI) mask_o = picked & (~picked + NCORES'(1));
        else                    mask_o = picked;
    end

endmodule

// File: rtl/msg_irq_router.sv
module msg_irq_router
    import irq_route_pkg::*;
#(
    parameter int NCORES = 8,
    localparam int IDXW  = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDXW-1:0]   cfg_core,
    input  logic [7:0]        cfg_phys_id,
    input  logic [7:0]        cfg_log_id,
    input  logic [3:0]        cfg_model,
    input  logic              req_valid,
    input  logic              req_is_cmd,
    input  logic [IDXW-1:0]   req_sender,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_data,
    output logic              out_valid,
    output logic [NCORES-1:0] out_mask,
    output logic [7:0]        out_vector,
    output logic [2:0]        out_dmode,
    output logic              out_trig,
    output logic              out_level,
    output logic              out_no_target
);

    core_cfg_t [NCORES-1:0] cfg_tab;
    core_cfg_t              cfg_wr;
    logic [7:0]             dec_dest;
    logic                   dec_logical;
    shorthand_e             dec_sh;
    logic [NCORES-1:0]      hits;
    logic [NCORES-1:0]      sel_mask;
    route_state_e           state_q, state_d;
    logic                   unused_bits;

    assign cfg_wr = '{phys: cfg_phys_id, logid: cfg_log_id, model: cfg_model};

    irq_core_cfg #(.NCORES(NCORES)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .core  (cfg_core),
        .wdata (cfg_wr),
        .cfg_o (cfg_tab)
    );

    // Field extraction: message vs command layout
    always_comb begin
        if (req_is_cmd) begin
            dec_dest    = req_addr[31:24];
            dec_logical = req_data[11];
            dec_sh      = shorthand_e'(req_data[19:18]);
        end else begin
            dec_dest    = req_addr[19:12];
            dec_logical = req_addr[2];
            dec_sh      = SH_NONE;
        end
    end

    assign unused_bits = ^{req_addr[23:20], req_addr[11:3], req_addr[1:0],
                           req_data[31:20], req_data[17:16], req_data[13:12]};

    for (genvar c = 0; c < NCORES; c++) begin : g_match
        irq_core_match u_match (
            .cfg     (cfg_tab[c]),
            .dest    (dec_dest),
            .logical (dec_logical),
            .hit     (hits[c])
        );
    end

    irq_target_select #(.NCORES(NCORES)) u_sel (
        .decoded (hits),
        .sh      (dec_sh),
        .sender  (req_sender),
        .dmode   (req_data[10:8]),
        .mask_o  (sel_mask)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: T_ACCEPT / T_WAIT from idle, T_CHAIN / T_DONE from emit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign out_valid = (state_q == ST_EMIT);

    // Result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_mask      <= '0;
            out_vector    <= '0;
            out_dmode     <= '0;
            out_trig      <= 1'b0;
            out_level     <= 1'b0;
            out_no_target <= 1'b0;
        end else if (req_valid) begin
            out_mask      <= sel_mask;
            out_vector    <= req_data[7:0];
            out_dmode     <= req_data[10:8];
            out_trig      <= req_data[15];
            out_level     <= req_data[14];
            out_no_target <= (sel_mask == '0);
        end
    end

    // R8: each request yields a valid pulse next cycle
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R8: no pulse without a request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R7: lowest-priority result has at most one target
    a_r7_lowpri_single: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dmode == DM_LOWPRI) |-> $onehot0(out_mask));

    // R6: all-but-self never includes the sender
    a_r6_self_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_cmd && req_data[19:18] == 2'd3)
        |=> (out_mask[$past(req_sender)] == 1'b0));

    // R3: physical broadcast reaches every core
    a_r3_phys_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_cmd && !req_addr[2] && req_addr[19:12] == 8'hFF
         && req_data[10:8] != DM_LOWPRI) |=> (&out_mask));

endmodule

// File: tb/msg_irq_router_tb_top.sv
module msg_irq_router_tb_top;

    typedef struct packed {
        logic        is_cmd;
        logic [2:0]  sender;
        logic [31:0] addr;
        logic [31:0] data;
        logic [7:0]  exp_mask;
        logic        exp_nt;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd0, 32'hFEE12000, 32'h00000031, 8'h04, 1'b0}, // R3 R1 phys hit
        '{1'b0, 3'd0, 32'hFEEFF000, 32'h00008042, 8'hFF, 1'b0}, // R3 broadcast
        '{1'b0, 3'd0, 32'hFEE33000, 32'h00000050, 8'h00, 1'b1}, // R9 no match
        '{1'b0, 3'd0, 32'hFEE05004, 32'h00004060, 8'h05, 1'b0}, // R4 flat
        '{1'b0, 3'd0, 32'hFEE56004, 32'h00000070, 8'h66, 1'b0}, // R5 mixed
        '{1'b0, 3'd0, 32'hFEE56004, 32'h00000171, 8'h02, 1'b0}, // R7 lowpri
        '{1'b0, 3'd0, 32'hFEE30004, 32'h00000080, 8'h00, 1'b1}, // R9 logical miss
        '{1'b1, 3'd5, 32'h00000000, 32'h00040090, 8'h20, 1'b0}, // R6 self
        '{1'b1, 3'd0, 32'h00000000, 32'h000800A0, 8'hFF, 1'b0}, // R6 all
        '{1'b1, 3'd2, 32'h00000000, 32'h000C00B0, 8'hFB, 1'b0}, // R6 others
        '{1'b1, 3'd0, 32'h00000000, 32'h000C01B1, 8'h02, 1'b0}, // R7 others+lowpri
        '{1'b1, 3'd3, 32'h17000000, 32'h000000C0, 8'h80, 1'b0}, // R2 phys cmd
        '{1'b1, 3'd3, 32'h58000000, 32'h000008C1, 8'h88, 1'b0}, // R2 logical cmd
        '{1'b0, 3'd0, 32'hFEE13008, 32'h000C80D0, 8'h08, 1'b0}, // R1 ignored bits
        '{1'b0, 3'd0, 32'hFEE56004, 32'h000002D2, 8'h66, 1'b0}  // R7 other mode
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_core = '0;
    logic [7:0]  cfg_phys_id = '0;
    logic [7:0]  cfg_log_id = '0;
    logic [3:0]  cfg_model = '0;
    logic        req_valid = 1'b0;
    logic        req_is_cmd = 1'b0;
    logic [2:0]  req_sender = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        out_valid;
    logic [7:0]  out_mask;
    logic [7:0]  out_vector;
    logic [2:0]  out_dmode;
    logic        out_trig;
    logic        out_level;
    logic        out_no_target;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    msg_irq_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_core(cfg_core), .cfg_phys_id(cfg_phys_id),
        .cfg_log_id(cfg_log_id), .cfg_model(cfg_model),
        .req_valid(req_valid), .req_is_cmd(req_is_cmd), .req_sender(req_sender),
        .req_addr(req_addr), .req_data(req_data),
        .out_valid(out_valid), .out_mask(out_mask), .out_vector(out_vector),
        .out_dmode(out_dmode), .out_trig(out_trig), .out_level(out_level),
        .out_no_target(out_no_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] c, input logic [7:0] p,
                             input logic [7:0] l, input logic [3:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_core = c; cfg_phys_id = p; cfg_log_id = l; cfg_model = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive one request, then sample the registered result one cycle later
    task automatic send(input logic cmd, input logic [2:0] snd,
                        input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_is_cmd = cmd; req_sender = snd; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset valid", 32'(out_valid), 32'd0);
        check("R10 reset mask", 32'(out_mask), 32'd0);
        check("R10 reset no_target", 32'(out_no_target), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle no valid", 32'(out_valid), 32'd0);

        // R10 reset IDs: phys ID equals index
        send(1'b0, 3'd0, 32'hFEE06000, 32'h0);
        check("R10 reset phys id", 32'(out_mask), 32'h40);

        // program: cores 0-3 flat, cores 4-7 cluster 5
        for (int i = 0; i < 8; i++) begin
            if (i < 4) cfg_write(3'(i), 8'(8'h10 + i), 8'(1 << i), 4'hF);
            else       cfg_write(3'(i), 8'(8'h10 + i), 8'(8'h50 | (1 << (i - 4))), 4'h0);
        end

        for (int k = 0; k < NV; k++) begin
            send(TBL[k].is_cmd, TBL[k].sender, TBL[k].addr, TBL[k].data);
            check($sformatf("R8 valid vec%0d", k), 32'(out_valid), 32'd1);
            check($sformatf("R3-6 mask vec%0d", k), 32'(out_mask), 32'(TBL[k].exp_mask));
            check($sformatf("R9 no_target vec%0d", k), 32'(out_no_target), 32'(TBL[k].exp_nt));
            check($sformatf("R1 vector vec%0d", k), 32'(out_vector), 32'(TBL[k].data[7:0]));
            check($sformatf("R1 dmode vec%0d", k), 32'(out_dmode), 32'(TBL[k].data[10:8]));
            check($sformatf("R2 trig vec%0d", k), 32'(out_trig), 32'(TBL[k].data[15]));
            check($sformatf("R2 level vec%0d", k), 32'(out_level), 32'(TBL[k].data[14]));
        end

        // R8: single-cycle pulse, outputs held afterwards
        @(negedge clk);
        check("R8 pulse ends", 32'(out_valid), 32'd0);
        check("R8 mask held", 32'(out_mask), 32'h66);

        // R7: lowest priority on an empty mask stays empty
        send(1'b0, 3'd0, 32'hFEE33000, 32'h00000100);
        check("R7 lowpri empty", 32'(out_mask), 32'h00);
        check("R9 lowpri empty flag", 32'(out_no_target), 32'd1);

        // R5: unsupported model never matches logically
        cfg_write(3'd4, 8'h14, 8'h51, 4'h3);
        send(1'b0, 3'd0, 32'hFEE51004, 32'h0);
        check("R5 other model", 32'(out_mask), 32'h01);

        // R10: reprogrammed physical ID takes effect
        cfg_write(3'd6, 8'h77, 8'h54, 4'h0);
        send(1'b0, 3'd0, 32'hFEE77000, 32'h0);
        check("R10 new phys id", 32'(out_mask), 32'h40);
        send(1'b0, 3'd0, 32'hFEE16000, 32'h0);
        check("R10 old phys id gone", 32'(out_mask), 32'h00);

        // R8: back-to-back requests give back-to-back results
        @(negedge clk);
        req_valid = 1'b1; req_is_cmd = 1'b0; req_addr = 32'hFEE10000; req_data = 32'h0;
        @(negedge clk);
        check("R8 chain first", 32'(out_mask), 32'h01);
        req_addr = 32'hFEE11000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 chain second valid", 32'(out_valid), 32'd1);
        check("R8 chain second", 32'(out_mask), 32'h02);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule